// File: doc/BRIEF.md
# ADC Result Register with Read Lock

This block keeps the most recent 10-bit conversion result and shows it to the bus as two read-only bytes, a high byte and a low byte. A select input chooses right or left alignment of the result within the 16-bit pair. The sequencer pulses a valid strobe with each new result. The bus raises a one-cycle read strobe for each byte it reads.

Software that wants the full result reads the low byte first and the high byte second. Between those two reads the block refuses new results, so the two bytes always come from the same conversion. Software that needs only 8 bits sets left alignment and reads the high byte alone. A lone high-byte read neither takes nor releases the lock.

Internally the raw 10-bit value is stored. Both byte views are derived from it combinationally, so a change of alignment shows at once. Lock control is a two-state machine. OPEN accepts results. HELD rejects them. The transitions are: GRAB (OPEN to HELD, on a low-byte read without a high-byte read in the same cycle), RELEASE (HELD to OPEN, on a high-byte read), and STAY (every other case, no change of state).

Top module: `adc_result_lock`

## Requirements
- R1: With right alignment (`left_align`=0), `byte_high[1:0]` equals result bits 9:8, `byte_high[7:2]` reads 0, and `byte_low` equals result bits 7:0.
- R2: With left alignment (`left_align`=1), `byte_high` equals result bits 9:2, `byte_low[7:6]` equals result bits 1:0, and `byte_low[5:0]` reads 0.
- R3: In OPEN, a low-byte read without a high-byte read in the same cycle moves the block to HELD. While the block is HELD and no high-byte read occurs, a result strobe is discarded and both bytes keep their values.
- R4: In HELD, a high-byte read returns the block to OPEN. A result strobe in that same cycle is accepted.
- R5: After reset both bytes read 0 and the block is OPEN.
- R6: A high-byte read in OPEN without a low-byte read leaves the block OPEN, and the next result updates the bytes normally.
- R7: In OPEN, a result strobe with no low-byte read in that cycle is shown on the bytes from the next clock edge. A result strobe in the same cycle as a lone low-byte read is discarded.
- R8: A change of `left_align` re-formats the stored value in the same cycle, without a clock edge.
- R9: In OPEN, low-byte and high-byte reads in the same cycle leave the block OPEN, and a result strobe in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_stb | input | 1 | New conversion result valid |
| res_val | input | 10 | Conversion result |
| left_align | input | 1 | 1 = left alignment, 0 = right alignment |
| rd_low_stb | input | 1 | Bus read of the low byte in this cycle |
| rd_high_stb | input | 1 | Bus read of the high byte in this cycle |
| byte_high | output | 8 | High-byte view of the stored result |
| byte_low | output | 8 | Low-byte view of the stored result |

## Verification
A result strobe, or a read strobe that moves the lock, takes effect at the next rising edge. The outputs carry it from that edge on, because one register sits between the strobes and the byte views. An alignment change needs no edge, since the formatter is purely combinational. The bench drives every input 1 ns after a rising edge and advances its reference model at the next edge. It samples both bytes 1 ns after that edge. For R8 it samples 1 ns after the alignment change alone, before any edge.

// File: rtl/adc_rdlock_pkg.sv
package adc_rdlock_pkg;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lk_state_t;

endpackage

// File: rtl/adc_rdlock_ctrl.sv
module adc_rdlock_ctrl
    import adc_rdlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic res_stb,
    input  logic rd_low_stb,
    input  logic rd_high_stb,
    output logic accept,
    output logic held
);

    lk_state_t state_q;
    lk_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            LK_OPEN: begin
                if (rd_low_stb && !rd_high_stb) begin
                    state_d = LK_HELD;              // GRAB
                    accept  = 1'b0;
                end else begin
                    accept  = res_stb;              // STAY
                end
            end
            LK_HELD: begin
                if (rd_high_stb) begin
                    state_d = LK_OPEN;              // RELEASE
                    accept  = res_stb;
                end else begin
                    accept  = 1'b0;                 // STAY
                end
            end
            default: begin
                state_d = LK_OPEN;
                accept  = 1'b0;
            end
        endcase
    end

    assign held = (state_q == LK_HELD);

endmodule

// File: rtl/adc_rdlock_store.sv
module adc_rdlock_store #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] raw
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw <= '0;
        end else if (load) begin
            raw <= din;
        end
    end

endmodule

// File: rtl/adc_rdlock_fmt.sv
module adc_rdlock_fmt #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  raw,
    input  logic              left_align,
    output logic [BYTE_W-1:0] hi,
    output logic [BYTE_W-1:0] lo
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAD_W  = WORD_W - RES_W;

    logic [WORD_W-1:0] word_r;
    logic [WORD_W-1:0] word_l;
    logic [WORD_W-1:0] word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign word_r = {{PAD_W{1'b0}}, raw};
            assign word_l = {raw, {PAD_W{1'b0}}};
        end else begin : g_full
            assign word_r = raw;
            assign word_l = raw;
        end
    endgenerate

    always_comb begin
        word = left_align ? word_l : word_r;
        hi   = word[WORD_W-1:BYTE_W];
        lo   = word[BYTE_W-1:0];
    end

endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_stb,
    input  logic [RES_W-1:0]  res_val,
    input  logic              left_align,
    input  logic              rd_low_stb,
    input  logic              rd_high_stb,
    output logic [BYTE_W-1:0] byte_high,
    output logic [BYTE_W-1:0] byte_low
);

    logic             accept;
    logic             held;
    logic [RES_W-1:0] raw_q;

    adc_rdlock_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_stb     (res_stb),
        .rd_low_stb  (rd_low_stb),
        .rd_high_stb (rd_high_stb),
        .accept      (accept),
        .held        (held)
    );

    adc_rdlock_store #(.RES_W(RES_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .din   (res_val),
        .raw   (raw_q)
    );

    adc_rdlock_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
        .raw        (raw_q),
        .left_align (left_align),
        .hi         (byte_high),
        .lo         (byte_low)
    );

endmodule

// File: rtl/adc_result_lock_chk.sv
module adc_result_lock_chk #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_stb,
    input logic [RES_W-1:0]  res_val,
    input logic              left_align,
    input logic              rd_low_stb,
    input logic              rd_high_stb,
    input logic [BYTE_W-1:0] byte_high,
    input logic [BYTE_W-1:0] byte_low,
    input logic              held,
    input logic [RES_W-1:0]  raw
);

    AST_RIGHT_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        !left_align |-> byte_high[7:2] == 6'd0);                        // R1

    AST_LEFT_LO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        left_align |-> byte_low[5:0] == 6'd0);                          // R2

    AST_GRAB_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !held && rd_low_stb && !rd_high_stb |=> held);                  // R3

    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        held && !rd_high_stb |=> $stable(raw));                         // R3

    AST_RELEASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        held && rd_high_stb |=> !held);                                 // R4

    AST_HIGH_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !held && rd_high_stb |=> !held);                                // R6

    AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !held && !rd_low_stb && res_stb |=> raw == $past(res_val));     // R7

    AST_PAIR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        !held && rd_low_stb && rd_high_stb && res_stb
            |=> !held && raw == $past(res_val));                        // R9

endmodule

bind adc_result_lock adc_result_lock_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_stb     (res_stb),
    .res_val     (res_val),
    .left_align  (left_align),
    .rd_low_stb  (rd_low_stb),
    .rd_high_stb (rd_high_stb),
    .byte_high   (byte_high),
    .byte_low    (byte_low),
    .held        (held),
    .raw         (raw_q)
);

// File: tb/test_adc_result_lock.sv
`timescale 1ns/1ps
module test_adc_result_lock;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_stb = 1'b0;
    logic [9:0] res_val = '0;
    logic       left_align = 1'b0;
    logic       rd_low_stb = 1'b0;
    logic       rd_high_stb = 1'b0;
    logic [7:0] byte_high;
    logic [7:0] byte_low;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model
    logic [9:0] m_raw  = '0;
    bit         m_held = 1'b0;

    always #2 clk = ~clk;

    adc_result_lock i_adc_result_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_stb     (res_stb),
        .res_val     (res_val),
        .left_align  (left_align),
        .rd_low_stb  (rd_low_stb),
        .rd_high_stb (rd_high_stb),
        .byte_high   (byte_high),
        .byte_low    (byte_low)
    );

    function automatic logic [15:0] view(input logic [9:0] r, input logic la);
        return la ? {r, 6'b0} : {6'b0, r};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk_bytes(input string tag);
        logic [15:0] w;
        w = view(m_raw, left_align);
        chk({tag, " high"}, byte_high, w[15:8]);
        chk({tag, " low"},  byte_low,  w[7:0]);
    endtask

    // one clock: drive, advance model at the edge, sample 1 ns later
    task automatic cyc(input string tag, input bit v, input logic [9:0] d,
                       input bit lo, input bit hi, input bit la);
        bit acc;
        res_stb = v; res_val = d; rd_low_stb = lo; rd_high_stb = hi; left_align = la;
        @(posedge clk);
        if (!m_held) begin
            acc = !(lo && !hi) && v;
            if (lo && !hi) m_held = 1'b1;
        end else begin
            acc = hi && v;
            if (hi) m_held = 1'b0;
        end
        if (acc) m_raw = d;
        #1;
        chk_bytes(tag);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R5 reset", byte_high, 8'h00);
        chk("R5 reset", byte_low, 8'h00);
        rst_n = 1'b1;
        cyc("R5 idle", 0, 10'h000, 0, 0, 0);

        // R7 and R1: plain load, right alignment
        cyc("R7 load", 1, 10'h2A5, 0, 0, 0);
        chk("R1 high", byte_high, 8'h02);
        chk("R1 low",  byte_low,  8'hA5);

        // R8 and R2: alignment change alone, no edge
        left_align = 1'b1;
        #1;
        chk("R8 R2 high", byte_high, 8'hA9);
        chk("R8 R2 low",  byte_low,  8'h40);
        left_align = 1'b0;
        #1;
        chk("R8 back high", byte_high, 8'h02);
        @(posedge clk); #1;

        // R3: grab, then results discarded while held
        cyc("R3 grab", 0, 10'h000, 1, 0, 0);
        cyc("R3 discard", 1, 10'h155, 0, 0, 0);
        cyc("R3 discard2", 1, 10'h0FF, 1, 0, 1);
        chk("R3 held high", byte_high, 8'hA9);
        // R4: release with same-cycle result accepted
        cyc("R4 release", 1, 10'h3C3, 0, 1, 1);
        chk("R4 new high", byte_high, 8'hF0);
        chk("R4 new low",  byte_low,  8'hC0);
        cyc("R4 open", 1, 10'h011, 0, 0, 0);

        // R6: high-only read does not lock
        cyc("R6 hi only", 0, 10'h000, 0, 1, 1);
        cyc("R6 update", 1, 10'h1E7, 0, 0, 1);
        chk("R6 high", byte_high, 8'h79);

        // R7: result with lone low read is discarded, then lock held
        cyc("R7 lo+res", 1, 10'h2AA, 1, 0, 0);
        chk("R7 kept low", byte_low, 8'hE7);
        cyc("R4 release2", 0, 10'h000, 0, 1, 0);

        // R9: both reads with a result in one cycle
        cyc("R9 pair", 1, 10'h0C8, 1, 1, 0);
        cyc("R9 still open", 1, 10'h301, 0, 0, 0);
        chk("R9 high", byte_high, 8'h03);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit v, lo, hi, la;
            v  = ($urandom % 3) != 0;
            lo = ($urandom % 4) == 0;
            hi = ($urandom % 4) == 0;
            la = ($urandom % 2) == 1;
            cyc(la ? "R2 R3 R4 rand" : "R1 R3 R4 rand", v, 10'($urandom), lo, hi, la);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule